// File: doc/BRIEF.md
# Cyclic Neighbour-Product Sum Tracker

This block scores permutations. Each offered permutation of 1..size, with size from 1 to 18, is extended by one fixed extra value, size+1, placed directly after the permuted values. The block then multiplies every element of the ring by its successor and adds up those products. The last element wraps round to the first, so the final product pairs the extra value with the first permuted value.

Across a round of permutations the block keeps the smallest and the largest score it has seen. A clear input empties both records, which starts a new round. A parameter picks the arithmetic. By default one multiplier walks the ring, taking one product per cycle. The other choice forms every product in one combinational stage.

The caller offers a permutation with a one-cycle valid strobe. In the default arithmetic it waits while busy is high, and it reads the score while done is high. The minimum and maximum stay readable at all times.

Top module: `cps_tracker`

## Requirements
- R1: The reported sum adds up the product of each ring element and the element after it, and the last ring element is paired with the first. Entries are 5-bit unsigned values from 1 to 19.
- R2: The ring holds the first `size` entries of `perm` in index order (entry k in bits 5k+4..5k), followed by one extra element equal to size+1.
- R3: Entries of `perm` at index `size` or above have no effect on the sum.
- R4: The sum is 14 bits wide and is exact for the largest ring, size 18.
- R5: With `in_valid` high and `busy` low at a rising edge, the permutation is accepted. `busy` is then high for size+1 cycles. `done` rises at the edge size+1 cycles after the accepting edge and stays high for exactly one cycle, with the finished sum on `sum`.
- R6: `in_valid` has no effect while `busy` is high.
- R7: `clear` sets `sum_min` to all ones and `sum_max` to zero at the next edge.
- R8: `sum_min` and `sum_max` change only at the edge that ends a `done` cycle. At that edge they take the smaller and the larger of their old value and `sum`.
- R9: When `clear` and `done` are high in the same cycle, `clear` wins, and the finished sum is not folded into either record.
- R10: Reset leaves `busy` and `done` low, `sum` at zero, `sum_min` at all ones and `sum_max` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Start a new round of min/max tracking |
| in_valid | input | 1 | Offer a permutation this cycle |
| size | input | 5 | Number of permuted entries, 1 to 18 |
| perm | input | 90 | Permuted entries, 5 bits each, entry 0 in the low bits |
| busy | output | 1 | Sum being accumulated, new offers ignored |
| done | output | 1 | One-cycle strobe, `sum` complete |
| sum | output | 14 | Cyclic neighbour-product sum |
| sum_min | output | 14 | Smallest sum since clear |
| sum_max | output | 14 | Largest sum since clear |

## Verification
Two pairs of events can fall in the same cycle. The first is a round clear arriving in the very cycle that a finished sum would be folded into the records. The bench raises `clear` at the falling edge where it sees `done` high. It then expects both records back at their empty values, not holding that sum. The second is a fresh offer arriving during a busy walk. The bench drives a short permutation in mid-walk and expects the original score on time, with no second `done` following it.

// File: rtl/cps_pkg.sv
package cps_pkg;

  // Successor of a ring position: the tail element (index top) and the
  // last physical slot both wrap round to position zero.
  function automatic int unsigned ring_succ(int unsigned pos, int unsigned top,
                                            int unsigned last);
    return (pos == top || pos == last) ? 0 : pos + 1;
  endfunction

  // Unsigned product of two entries, widened before multiplying.
  function automatic int unsigned pair_prod(int unsigned a, int unsigned b);
    return a * b;
  endfunction

endpackage

// File: rtl/cps_ring.sv
module cps_ring #(
  parameter int MAX_N = 18,
  parameter int EW    = 5,
  parameter int NW    = 5,
  localparam int POS  = MAX_N + 1
) (
  input  logic [NW-1:0]        size,
  input  logic [MAX_N*EW-1:0]  perm,
  output logic [POS*EW-1:0]    ring
);

  logic [EW-1:0] tail;
  assign tail = EW'(size) + EW'(1);

  // Slot g: permuted entry below size, the fixed tail at size, zero above.
  for (genvar g = 0; g < MAX_N; g++) begin : g_slot
    assign ring[g*EW +: EW] = (NW'(g) < size)  ? perm[g*EW +: EW] :
                              (NW'(g) == size) ? tail : '0;
  end
  assign ring[MAX_N*EW +: EW] = (size == NW'(MAX_N)) ? tail : '0;

endmodule

// File: rtl/cps_accum.sv
module cps_accum #(
  parameter int MAX_N      = 18,
  parameter int EW         = 5,
  parameter int SW         = 14,
  parameter int NW         = 5,
  parameter bit SEQUENTIAL = 1'b1,
  localparam int POS       = MAX_N + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NW-1:0]      size,
  input  logic [POS*EW-1:0]  ring,
  output logic               busy,
  output logic               done,
  output logic [SW-1:0]      sum
);
  import cps_pkg::*;

  logic [EW-1:0] ring_a [POS];
  for (genvar g = 0; g < POS; g++) begin : g_unpack
    assign ring_a[g] = ring[g*EW +: EW];
  end

  if (SEQUENTIAL) begin : g_seq
    logic          run_q, done_q;
    logic [NW-1:0] idx_q, top_q, succ;
    logic [EW-1:0] ring_q [POS];
    logic [SW-1:0] acc_q, step_prod;
    logic          accept, last_step;

    assign accept    = start && !run_q;
    assign last_step = run_q && (idx_q == top_q);
    assign succ      = NW'(ring_succ(int'(idx_q), int'(top_q), POS - 1));
    assign step_prod = SW'(pair_prod(int'(ring_q[idx_q]), int'(ring_q[succ])));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q  <= 1'b0;
        done_q <= 1'b0;
        idx_q  <= '0;
        top_q  <= '0;
        acc_q  <= '0;
        for (int i = 0; i < POS; i++) ring_q[i] <= '0;
      end else begin
        done_q <= last_step;
        if (accept) begin
          run_q <= 1'b1;
          idx_q <= '0;
          top_q <= size;
          acc_q <= '0;
          for (int i = 0; i < POS; i++) ring_q[i] <= ring_a[i];
        end else if (run_q) begin
          acc_q <= acc_q + step_prod;
          idx_q <= idx_q + NW'(1);
          if (last_step) run_q <= 1'b0;
        end
      end
    end

    assign busy = run_q;
    assign done = done_q;
    assign sum  = acc_q;

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
    assert_accept_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (run_q && idx_q == '0 && !done_q));
    assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && start && !last_step) |=> (run_q && $stable(top_q)));
    assert_walk_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      last_step |=> (!run_q && done_q));
  end else begin : g_comb
    logic          done_q;
    logic [SW-1:0] acc_q, total;

    always_comb begin
      total = '0;
      for (int i = 0; i < POS; i++) begin
        total = total + SW'(pair_prod(int'(ring_a[i]),
                  int'(ring_a[ring_succ(i, int'(size), POS - 1)])));
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_q <= 1'b0;
        acc_q  <= '0;
      end else begin
        done_q <= start;
        if (start) acc_q <= total;
      end
    end

    assign busy = 1'b0;
    assign done = done_q;
    assign sum  = acc_q;

    assert_comb_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done_q);
  end

endmodule

// File: rtl/cps_extrema.sv
module cps_extrema #(
  parameter int SW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          done,
  input  logic [SW-1:0] sum,
  output logic [SW-1:0] sum_min,
  output logic [SW-1:0] sum_max
);

  logic fold;
  assign fold = done && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sum_min <= '1;
      sum_max <= '0;
    end else if (fold) begin
      if (sum < sum_min) sum_min <= sum;
      if (sum > sum_max) sum_max <= sum;
    end
  end

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sum_min == '1 && sum_max == '0));
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !clear) |=> ($stable(sum_min) && $stable(sum_max)));
  assert_fold_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fold |=> (sum_min <= $past(sum) && sum_max >= $past(sum)));
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && done) |=> (sum_max == '0));

endmodule

// File: rtl/cps_tracker.sv
module cps_tracker #(
  parameter int MAX_N      = 18,
  parameter int EW         = 5,
  parameter int SW         = 14,
  parameter bit SEQUENTIAL = 1'b1,
  localparam int NW        = $clog2(MAX_N + 2),
  localparam int POS       = MAX_N + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                in_valid,
  input  logic [NW-1:0]       size,
  input  logic [MAX_N*EW-1:0] perm,
  output logic                busy,
  output logic                done,
  output logic [SW-1:0]       sum,
  output logic [SW-1:0]       sum_min,
  output logic [SW-1:0]       sum_max
);

  logic [POS*EW-1:0] ring;

  cps_ring #(.MAX_N(MAX_N), .EW(EW), .NW(NW)) u_ring (
    .size(size), .perm(perm), .ring(ring)
  );

  cps_accum #(.MAX_N(MAX_N), .EW(EW), .SW(SW), .NW(NW),
              .SEQUENTIAL(SEQUENTIAL)) u_accum (
    .clk(clk), .rst_n(rst_n), .start(in_valid), .size(size), .ring(ring),
    .busy(busy), .done(done), .sum(sum)
  );

  cps_extrema #(.SW(SW)) u_extrema (
    .clk(clk), .rst_n(rst_n), .clear(clear), .done(done), .sum(sum),
    .sum_min(sum_min), .sum_max(sum_max)
  );

  assert_reset_state_R10: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && sum == '0 && sum_max == '0));

endmodule

// File: tb/sim_cps_tracker.sv
module sim_cps_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0, clear = 1'b0, in_valid = 1'b0;
  logic [4:0] size = 5'd1;
  logic [89:0] perm = '0;
  logic busy, done;
  logic [13:0] sum, sum_min, sum_max;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cps_tracker u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .size(size), .perm(perm), .busy(busy), .done(done), .sum(sum),
    .sum_min(sum_min), .sum_max(sum_max)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_sum(input int n, input logic [89:0] pv);
    int q[$];
    int s = 0;
    for (int i = 0; i < n; i++) q.push_back(int'(pv[i*5 +: 5]));
    q.push_back(n + 1);
    foreach (q[i]) s += q[i] * q[(i + 1) % q.size()];
    return s;
  endfunction

  // Behavioural model, advanced on each rising edge.
  int m_cnt = 0, m_sum = 0, m_pend = 0, m_min = 16383, m_max = 0;
  bit m_busy = 0, m_done = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_done = 0; m_sum = 0; m_min = 16383; m_max = 0;
    end else begin
      if (clear) begin m_min = 16383; m_max = 0; end
      else if (m_done) begin
        if (m_sum < m_min) m_min = m_sum;
        if (m_sum > m_max) m_max = m_sum;
      end
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; m_sum = m_pend; end
      end else if (in_valid) begin
        m_pend = ref_sum(int'(size), perm);
        m_cnt = int'(size) + 1;
        m_busy = 1;
      end
    end
  end

  // Compare against the model away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy == m_busy, "R5 busy", int'(busy), int'(m_busy));
      chk(done == m_done, "R5 done", int'(done), int'(m_done));
      if (m_done) chk(int'(sum) == m_sum, "R1 sum", int'(sum), m_sum);
      chk(int'(sum_min) == m_min, "R8 min", int'(sum_min), m_min);
      chk(int'(sum_max) == m_max, "R8 max", int'(sum_max), m_max);
    end
  end

  function automatic logic [89:0] mk(input int n, input int vals[18], input int fill);
    logic [89:0] v;
    for (int i = 0; i < 18; i++) v[i*5 +: 5] = 5'(i < n ? vals[i] : fill);
    return v;
  endfunction

  task automatic offer(input int n, input logic [89:0] pv);
    @(negedge clk);
    size = 5'(n); perm = pv; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Offer, wait for done, check value and latency; optionally clear then.
  task automatic run(input int n, input logic [89:0] pv, input int exp,
                     input string tag, input bit clr_at_done);
    int cnt = 1;
    offer(n, pv);
    while (!done && cnt < 60) begin @(negedge clk); cnt++; end
    chk(int'(sum) == exp, tag, int'(sum), exp);
    chk(cnt == n + 2, "R5 latency", cnt, n + 2);
    if (clr_at_done) clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(done == 1'b0, "R5 one-cycle done", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int v[18];
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 0 && done == 0, "R10 flags", int'({busy, done}), 0);
    chk(sum == 0, "R10 sum", int'(sum), 0);
    chk(sum_min == 14'h3FFF, "R10 min", int'(sum_min), 16383);
    chk(sum_max == 0, "R10 max", int'(sum_max), 0);
    rst_n = 1'b1;

    v = '{default: 0}; v[0] = 1;
    run(1, mk(1, v, 0), 4, "R1 size1", 0);
    v[0] = 3; v[1] = 1; v[2] = 2;
    run(3, mk(3, v, 0), 25, "R1 size3", 0);
    for (int i = 0; i < 4; i++) v[i] = i + 1;
    run(4, mk(4, v, 0), 45, "R2 tail", 0);
    v[0] = 1; v[1] = 2;
    run(2, mk(2, v, 31), 11, "R3 ignored", 0);
    for (int i = 0; i < 18; i++) v[i] = 18 - i;
    run(18, mk(18, v, 0), 2299, "R4 largest", 0);
    chk(sum_min == 4, "R8 min round", int'(sum_min), 4);
    chk(sum_max == 2299, "R8 max round", int'(sum_max), 2299);

    // R6: new offer in mid-walk is ignored
    for (int i = 0; i < 5; i++) v[i] = i + 1;
    offer(5, mk(5, v, 0));
    @(negedge clk);
    v[0] = 1;
    offer(1, mk(1, v, 0));
    while (!done) @(negedge clk);
    chk(sum == 76, "R6 busy offer ignored", int'(sum), 76);
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0, "R6 no second walk", int'({busy, done}), 0);

    // R7 clear while idle
    @(negedge clk); clear = 1'b1; @(negedge clk); clear = 1'b0;
    chk(sum_min == 14'h3FFF, "R7 min", int'(sum_min), 16383);
    chk(sum_max == 0, "R7 max", int'(sum_max), 0);
    v[0] = 3; v[1] = 1; v[2] = 2;
    run(3, mk(3, v, 0), 25, "R1 new round", 0);
    @(negedge clk);
    chk(sum_min == 25 && sum_max == 25, "R8 first fold", int'(sum_max), 25);

    // R9 clear coinciding with done
    v[0] = 1; v[1] = 2;
    run(2, mk(2, v, 0), 11, "R1 before clash", 1);
    chk(sum_min == 14'h3FFF, "R9 min", int'(sum_min), 16383);
    chk(sum_max == 0, "R9 max", int'(sum_max), 0);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule